// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Sequencer

This block takes one warp-wide shared-memory request, a byte address for every lane plus a mask of the lanes taking part, and works out how the request can be spread over cycles. Every active lane gets a slot number. Two lanes that touch different words held in one bank never share a slot. Lanes that read the very same word are merged into one broadcast access. A slot count comes out alongside, so the issuing pipeline knows how many slots to stall for.

The warp is cut into `NUM_PARTS` equal parts, which are walked one after another. No slot is shared between parts. Merging only happens inside a part. When broadcast limiting is requested, each broadcast word is moved to a private slot, numbered upward from `LANES`, instead of riding along in a bank slot. The block walks the lanes one per clock. A request takes `LANES + 1` busy cycles, and a single-cycle `done` pulse then marks the results as valid. The results hold until the next accepted request.

Top module: `smem_bank_sequencer`

## Requirements
- R1: Reset clears the outputs: after reset `busy`, `done`, `slot_count` and every lane slot read 0.
- R2: A lane's bank is (address / `WORD_BYTES`) modulo `NUM_BANKS`. Each bank holds a counter, cleared at request start. Lanes are taken in increasing index order. An active lane whose word is new in its part takes its bank's counter value as its slot, and that counter then goes up by one.
- R3: Two active lanes whose addresses fall in the same bank but in different words never receive the same slot.
- R4: An inactive lane reads slot 0 and leaves the bank counters untouched, so the lanes after it are numbered as if it were absent.
- R5: At the first lane of part p, any bank counter below p·(`LANES`/`NUM_PARTS`) is raised to that value. As a result, every non-broadcast slot of a lane in part p lies in [p·L, (p+1)·L), where L = `LANES`/`NUM_PARTS`.
- R6: With `bcast_limit` low, a lane whose word was already seen in its part copies the slot of the first lane of that word and does not advance any counter.
- R7: With `bcast_limit` high, the first repeat of a word in a part moves that word's first lane, and every lane sharing the word, to a broadcast slot. Broadcast slots are handed out as `LANES`, `LANES`+1, … in the order the repeats are met over the whole warp. The bank slot the first lane had taken stays consumed.
- R8: Equal words in different parts are never merged. Each part treats the word as new.
- R9: `slot_count` equals the largest slot over the active lanes plus one, or 0 when no lane is active.
- R10: `start` is taken only while idle. `busy` is then high for `LANES`+1 cycles, starting in the cycle after the accepting edge. `done` is high for the single cycle after `busy` falls. A `start` seen while busy is ignored. The slots and `slot_count` stay unchanged while idle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| bcast_limit | input | 1 | 1: each broadcast word takes its own slot from `LANES` upward |
| lane_active | input | LANES | Bit l set: lane l takes part |
| lane_addr | input | LANES*ADDR_W | Byte address of lane l at bits [l*ADDR_W +: ADDR_W] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: results valid |
| lane_slot | output | LANES*SLOT_W | Slot of lane l at bits [l*SLOT_W +: SLOT_W], SLOT_W = clog2(2*LANES) |
| slot_count | output | SLOT_W+1 | Largest active slot plus one |

## Verification
The checker reads `lane_active` and `lane_addr` at the ports when `done` is high, so it relies on the requester keeping both inputs steady from the accepting edge until `done` has been seen. The bench therefore drives a new request only while the block is idle, and it leaves the inputs untouched through the `done` cycle. Extra `start` pulses are injected only in the middle of a busy window. The patterns include spread words, a single hot bank, one shared word with and without limiting, sparse masks, an empty mask, and pseudo-random addresses packed into a small window so that both conflicts and broadcasts occur.

// File: rtl/smem_seq_pkg.sv
// Package: shared types of the bank conflict sequencer.
package smem_seq_pkg;

    // Sequencer phase: idle, walking the lanes, summing up the result
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_SUM  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/smem_bank_counters.sv
// Per-bank slot counters.
// Assumes: NUM_BANKS is a power of two and at least 2; the base never
// exceeds the range of SLOT_W.
// One counter per bank gives the next free slot of that bank. On a raise
// request, every counter below the base is lifted to it. The lifted
// value is visible in the same cycle and is also stored.
module smem_bank_counters #(
    parameter int NUM_BANKS = 16,
    parameter int SLOT_W    = 6,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              raise,
    input  logic [SLOT_W-1:0] base,
    input  logic [BANK_W-1:0] bank,
    input  logic              bump,
    output logic [SLOT_W-1:0] cur
);

    logic [SLOT_W-1:0] cnt_q [NUM_BANKS];
    logic [SLOT_W-1:0] eff   [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Effective value after an optional raise to the part base
        always_comb begin
            eff[b] = (raise && (cnt_q[b] < base)) ? base : cnt_q[b];
        end

        // Store the raised value and count up a used bank
        always_ff @(posedge clk) begin
            if (!rst_n || init) begin
                cnt_q[b] <= '0;
            end else if (bump && (bank == BANK_W'(b))) begin
                cnt_q[b] <= eff[b] + SLOT_W'(1);
            end else begin
                cnt_q[b] <= eff[b];
            end
        end
    end

    // Slot offered to the selected bank
    always_comb begin
        cur = eff[bank];
    end

endmodule

// File: rtl/smem_word_table.sv
// Table of words already seen in the current part.
// Assumes: every word is inserted at most once between clears, so at
// most one entry matches; no more than DEPTH inserts happen per part.
// A lookup returns the entry holding the word, the lane that owns it
// and whether it has become a broadcast. A clear empties the table in
// the same cycle: lookups miss and an insert lands in entry 0.
module smem_word_table #(
    parameter int DEPTH   = 16,
    parameter int WORD_W  = 30,
    parameter int OWNER_W = 5,
    parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [WORD_W-1:0]  lookup,
    input  logic               ins,
    input  logic [OWNER_W-1:0] ins_owner,
    input  logic               mark,
    input  logic [IDX_W-1:0]   mark_idx,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [OWNER_W-1:0] hit_owner,
    output logic               hit_bcast
);

    logic [DEPTH-1:0]   valid_q;
    logic [WORD_W-1:0]  word_q  [DEPTH];
    logic [OWNER_W-1:0] owner_q [DEPTH];
    logic [DEPTH-1:0]   bcast_q;
    logic [IDX_W-1:0]   ptr_q;
    logic [IDX_W-1:0]   wptr;
    logic [DEPTH-1:0]   match;

    // Compare the lookup word against every live entry
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        assign match[e] = valid_q[e] && (word_q[e] == lookup);
    end

    // Encode the matching entry and pick its fields
    always_comb begin
        hit       = !clear && (|match);
        hit_idx   = '0;
        hit_owner = '0;
        hit_bcast = 1'b0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (match[e]) begin
                hit_idx   = IDX_W'(e);
                hit_owner = owner_q[e];
                hit_bcast = bcast_q[e];
            end
        end
        wptr = clear ? '0 : ptr_q;
    end

    // Clear, insert and broadcast marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            bcast_q <= '0;
            ptr_q   <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                word_q[e]  <= '0;
                owner_q[e] <= '0;
            end
        end else begin
            if (clear) begin
                valid_q <= '0;
                ptr_q   <= '0;
            end
            if (ins) begin
                valid_q[wptr] <= 1'b1;
                bcast_q[wptr] <= 1'b0;
                word_q[wptr]  <= lookup;
                owner_q[wptr] <= ins_owner;
                ptr_q         <= wptr + IDX_W'(1);
            end
            if (mark) begin
                bcast_q[mark_idx] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/smem_slot_store.sv
// Per-lane slot registers with a max reduction.
// Assumes: the two write ports never address the same lane in one cycle.
// The store holds the slot of every lane and lets the owner of a word be
// read back or rewritten. It also gives the count of slots used by the
// active lanes.
module smem_slot_store #(
    parameter int LANES  = 32,
    parameter int SLOT_W = 6,
    parameter int LANE_W = $clog2(LANES),
    parameter int CNT_W  = SLOT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic [LANES-1:0]        act,
    input  logic                    we,
    input  logic [LANE_W-1:0]       widx,
    input  logic [SLOT_W-1:0]       wdata,
    input  logic                    we2,
    input  logic [LANE_W-1:0]       widx2,
    input  logic [SLOT_W-1:0]       wdata2,
    input  logic [LANE_W-1:0]       rd_idx,
    output logic [SLOT_W-1:0]       rd_data,
    output logic [LANES*SLOT_W-1:0] slots_flat,
    output logic [CNT_W-1:0]        count_next
);

    logic [SLOT_W-1:0] slot_q [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Hold one lane's slot; the current lane or the converted owner writes
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                slot_q[l] <= '0;
            end else if (we && (widx == LANE_W'(l))) begin
                slot_q[l] <= wdata;
            end else if (we2 && (widx2 == LANE_W'(l))) begin
                slot_q[l] <= wdata2;
            end
        end
        assign slots_flat[l*SLOT_W +: SLOT_W] = slot_q[l];
    end

    // Read port for the owner of a merged word
    always_comb begin
        rd_data = slot_q[rd_idx];
    end

    // Largest active slot plus one, zero when nothing is active
    always_comb begin
        logic [SLOT_W-1:0] mx;
        logic              any;
        mx  = '0;
        any = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (act[l]) begin
                any = 1'b1;
                if (slot_q[l] > mx) mx = slot_q[l];
            end
        end
        count_next = any ? (CNT_W'(mx) + CNT_W'(1)) : '0;
    end

endmodule

// File: rtl/smem_bank_sequencer.sv
// Shared-memory bank conflict sequencer (top).
// Assumes: LANES, NUM_BANKS and WORD_BYTES are powers of two; WORD_BYTES
// and NUM_BANKS are at least 2; NUM_PARTS divides LANES with at least
// two lanes per part; the inputs stay steady from the accepting edge
// until done.
// The top latches a request and walks one lane per clock. Each active
// lane is given a slot from its bank counter, from the owner of a
// repeated word, or from the broadcast counter. One summing cycle then
// produces the slot count.
module smem_bank_sequencer
    import smem_seq_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int NUM_BANKS  = 16,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter int NUM_PARTS  = 2,
    parameter int SLOT_W     = $clog2(2 * LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    bcast_limit,
    input  logic [LANES-1:0]        lane_active,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    output logic                    busy,
    output logic                    done,
    output logic [LANES*SLOT_W-1:0] lane_slot,
    output logic [SLOT_W:0]         slot_count
);

    localparam int LANE_W     = $clog2(LANES);
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int WB_W       = $clog2(WORD_BYTES);
    localparam int WORD_W     = ADDR_W - WB_W;
    localparam int CNT_W      = SLOT_W + 1;
    localparam int PART_LANES = LANES / NUM_PARTS;
    localparam int TAB_W      = (PART_LANES > 1) ? $clog2(PART_LANES) : 1;

    seq_state_t              state_q;
    logic [LANE_W-1:0]       idx_q;
    logic [LANES-1:0]        act_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic                    limit_q;
    logic [SLOT_W-1:0]       bnext_q;
    logic                    done_q;
    logic [CNT_W-1:0]        count_q;

    logic                    accept;
    logic                    scan;
    logic                    part_start;
    logic [ADDR_W-1:0]       cur_addr;
    logic [WORD_W-1:0]       cur_word;
    logic [BANK_W-1:0]       cur_bank;
    logic                    cur_act;
    logic                    hit;
    logic [TAB_W-1:0]        hit_idx;
    logic [LANE_W-1:0]       hit_owner;
    logic                    hit_bcast;
    logic                    fresh;
    logic                    convert;
    logic [SLOT_W-1:0]       bank_slot;
    logic [SLOT_W-1:0]       owner_slot;
    logic [SLOT_W-1:0]       lane_wdata;
    logic [CNT_W-1:0]        count_next;

    // Decode the lane under scan and decide how it gets its slot
    always_comb begin
        accept     = start && (state_q == ST_IDLE);
        scan       = (state_q == ST_SCAN);
        part_start = scan && ((int'(idx_q) % PART_LANES) == 0);
        cur_addr   = addr_q[idx_q*ADDR_W +: ADDR_W];
        cur_word   = WORD_W'(cur_addr >> WB_W);
        cur_bank   = cur_word[BANK_W-1:0];
        cur_act    = scan && act_q[idx_q];
        fresh      = cur_act && !hit;
        convert    = cur_act && hit && limit_q && !hit_bcast;
        if (fresh)        lane_wdata = bank_slot;
        else if (convert) lane_wdata = bnext_q;
        else              lane_wdata = owner_slot;
    end

    smem_bank_counters #(
        .NUM_BANKS (NUM_BANKS),
        .SLOT_W    (SLOT_W),
        .BANK_W    (BANK_W)
    ) u_counters (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (accept),
        .raise (part_start),
        .base  (SLOT_W'(idx_q)),
        .bank  (cur_bank),
        .bump  (fresh),
        .cur   (bank_slot)
    );

    smem_word_table #(
        .DEPTH   (PART_LANES),
        .WORD_W  (WORD_W),
        .OWNER_W (LANE_W),
        .IDX_W   (TAB_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (part_start),
        .lookup    (cur_word),
        .ins       (fresh),
        .ins_owner (idx_q),
        .mark      (convert),
        .mark_idx  (hit_idx),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_owner (hit_owner),
        .hit_bcast (hit_bcast)
    );

    smem_slot_store #(
        .LANES  (LANES),
        .SLOT_W (SLOT_W),
        .LANE_W (LANE_W),
        .CNT_W  (CNT_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .act        (act_q),
        .we         (cur_act),
        .widx       (idx_q),
        .wdata      (lane_wdata),
        .we2        (convert),
        .widx2      (hit_owner),
        .wdata2     (bnext_q),
        .rd_idx     (hit_owner),
        .rd_data    (owner_slot),
        .slots_flat (lane_slot),
        .count_next (count_next)
    );

    // Request capture, lane walk and result summing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            act_q   <= '0;
            addr_q  <= '0;
            limit_q <= 1'b0;
            bnext_q <= '0;
            done_q  <= 1'b0;
            count_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        act_q   <= lane_active;
                        addr_q  <= lane_addr;
                        limit_q <= bcast_limit;
                        bnext_q <= SLOT_W'(LANES);
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (convert) bnext_q <= bnext_q + SLOT_W'(1);
                    idx_q <= idx_q + LANE_W'(1);
                    if (idx_q == LANE_W'(LANES - 1)) state_q <= ST_SUM;
                end
                ST_SUM: begin
                    count_q <= count_next;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign slot_count = count_q;

endmodule

// File: rtl/smem_bank_sequencer_chk.sv
// Checker for the bank conflict sequencer, bound to the top.
// Assumes: lane_active and lane_addr stay steady from the accepting edge
// until done, so the port values at done describe the request.
module smem_bank_sequencer_chk #(
    parameter int LANES      = 32,
    parameter int NUM_BANKS  = 16,
    parameter int WORD_BYTES = 4,
    parameter int ADDR_W     = 32,
    parameter int NUM_PARTS  = 2,
    parameter int SLOT_W     = $clog2(2 * LANES)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic [LANES-1:0]        lane_active,
    input logic [LANES*ADDR_W-1:0] lane_addr,
    input logic [LANES*SLOT_W-1:0] lane_slot,
    input logic [SLOT_W:0]         slot_count
);

    localparam int WB_W       = $clog2(WORD_BYTES);
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int WORD_W     = ADDR_W - WB_W;
    localparam int PART_LANES = LANES / NUM_PARTS;

    logic [WORD_W-1:0] word_of [LANES];
    logic [SLOT_W-1:0] slot_of [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign word_of[l] = WORD_W'(lane_addr[l*ADDR_W +: ADDR_W] >> WB_W);
        assign slot_of[l] = lane_slot[l*SLOT_W +: SLOT_W];

        // R4: an inactive lane carries slot 0
        p_idle_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !lane_active[l]) |-> (slot_of[l] == '0));

        // R9: the count covers every active slot
        p_count_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (done && lane_active[l]) |-> ((SLOT_W+1)'(slot_of[l]) < slot_count));

        // R5: a bank slot stays inside its part's window
        p_part_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (done && lane_active[l] && (int'(slot_of[l]) < LANES)) |->
            ((int'(slot_of[l]) >= (l / PART_LANES) * PART_LANES) &&
             (int'(slot_of[l]) <  (l / PART_LANES + 1) * PART_LANES)));

        for (genvar m = l + 1; m < LANES; m++) begin : g_pair
            // R3: different words of one bank never share a slot
            p_bank_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (done && lane_active[l] && lane_active[m] &&
                 (word_of[l][BANK_W-1:0] == word_of[m][BANK_W-1:0]) &&
                 (word_of[l] != word_of[m])) |-> (slot_of[l] != slot_of[m]));
        end
    end

    // R10: an accepted start raises busy
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: done follows the fall of busy
    p_done_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10: done lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: results hold while idle without a new request
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(lane_slot) && $stable(slot_count)));

endmodule

bind smem_bank_sequencer smem_bank_sequencer_chk #(
    .LANES      (LANES),
    .NUM_BANKS  (NUM_BANKS),
    .WORD_BYTES (WORD_BYTES),
    .ADDR_W     (ADDR_W),
    .NUM_PARTS  (NUM_PARTS),
    .SLOT_W     (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .lane_active (lane_active),
    .lane_addr   (lane_addr),
    .lane_slot   (lane_slot),
    .slot_count  (slot_count)
);

// File: tb/smem_bank_sequencer_tb.sv
// Bench for the bank conflict sequencer: a behavioural reference model
// computes the expected slots, and busy/done are compared on every clock.
module smem_bank_sequencer_tb;

    localparam int LANES  = 32;
    localparam int BANKS  = 16;
    localparam int WBYTES = 4;
    localparam int AW     = 32;
    localparam int PARTS  = 2;
    localparam int SW     = $clog2(2 * LANES);
    localparam int PL     = LANES / PARTS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 bcast_limit = 1'b0;
    logic [LANES-1:0]     lane_active = '0;
    logic [LANES*AW-1:0]  lane_addr = '0;
    logic                 busy;
    logic                 done;
    logic [LANES*SW-1:0]  lane_slot;
    logic [SW:0]          slot_count;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    logic [31:0] rng = 32'h1d2c3b4a;

    int stim_addr [LANES];
    int exp_slot  [LANES];
    int exp_count;

    always #2 clk = ~clk;

    smem_bank_sequencer #(
        .LANES(LANES), .NUM_BANKS(BANKS), .WORD_BYTES(WBYTES),
        .ADDR_W(AW), .NUM_PARTS(PARTS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bcast_limit(bcast_limit),
        .lane_active(lane_active), .lane_addr(lane_addr), .busy(busy),
        .done(done), .lane_slot(lane_slot), .slot_count(slot_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'(rng & 32'h7fffffff);
    endfunction

    // Reference: per-part walk with bank counters, a seen-word queue and broadcasts
    task automatic model(input bit lim);
        int cnt [BANKS];
        int bc;
        int mx;
        bit any;
        bc = LANES;
        foreach (cnt[b]) cnt[b] = 0;
        for (int p = 0; p < PARTS; p++) begin
            int q_word [$];
            int q_own  [$];
            bit q_flag [$];
            for (int b = 0; b < BANKS; b++) if (cnt[b] < p * PL) cnt[b] = p * PL;
            for (int l = p * PL; l < (p + 1) * PL; l++) begin
                int w;
                int f;
                exp_slot[l] = 0;
                if (!lane_active[l]) continue;
                w = stim_addr[l] / WBYTES;
                f = -1;
                for (int k = 0; k < q_word.size(); k++) if (q_word[k] == w) f = k;
                if (f >= 0) begin
                    if (lim && !q_flag[f]) begin
                        exp_slot[q_own[f]] = bc;
                        bc++;
                        q_flag[f] = 1'b1;
                    end
                    exp_slot[l] = exp_slot[q_own[f]];
                end else begin
                    exp_slot[l] = cnt[w % BANKS];
                    cnt[w % BANKS]++;
                    q_word.push_back(w);
                    q_own.push_back(l);
                    q_flag.push_back(1'b0);
                end
            end
        end
        mx = 0;
        any = 1'b0;
        for (int l = 0; l < LANES; l++) if (lane_active[l]) begin
            any = 1'b1;
            if (exp_slot[l] > mx) mx = exp_slot[l];
        end
        exp_count = any ? mx + 1 : 0;
    endtask

    // Issue one request, compare busy/done each clock, then the results
    task automatic run_case(input string req, input logic [LANES-1:0] act,
                            input bit lim, input int poke);
        @(negedge clk);
        lane_active = act;
        bcast_limit = lim;
        for (int l = 0; l < LANES; l++) lane_addr[l*AW +: AW] = AW'(stim_addr[l]);
        model(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= LANES + 1; k++) begin
            check(busy === 1'b1, "R10", "busy during walk", int'(busy), 1);
            check(done === 1'b0, "R10", "done during walk", int'(done), 0);
            start = (k == poke);
            @(negedge clk);
        end
        start = 1'b0;
        check(busy === 1'b0, "R10", "busy after walk", int'(busy), 0);
        check(done === 1'b1, "R10", "done pulse", int'(done), 1);
        for (int l = 0; l < LANES; l++)
            check(int'(lane_slot[l*SW +: SW]) == exp_slot[l], req,
                  $sformatf("lane %0d slot", l), int'(lane_slot[l*SW +: SW]), exp_slot[l]);
        check(int'(slot_count) == exp_count, {req, " R9"}, "slot_count",
              int'(slot_count), exp_count);
        @(negedge clk);
        check(done === 1'b0, "R10", "done single cycle", int'(done), 0);
        check(int'(lane_slot[0 +: SW]) == exp_slot[0], "R10", "slot hold",
              int'(lane_slot[0 +: SW]), exp_slot[0]);
        check(int'(slot_count) == exp_count, "R10", "count hold",
              int'(slot_count), exp_count);
    endtask

    // Watchdog: an overrun is a failed check and still reaches the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy", int'(busy), 0);
        check(done === 1'b0, "R1", "done", int'(done), 0);
        check(slot_count === '0, "R1", "slot_count", int'(slot_count), 0);
        check(lane_slot === '0, "R1", "lane slots zero", 0, 0);
        rst_n = 1'b1;

        // R2 R5: distinct words, one per bank per part
        for (int l = 0; l < LANES; l++) stim_addr[l] = l * WBYTES;
        run_case("R2 R5", '1, 1'b0, 0);
        check(exp_slot[PL] == PL, "R5", "model part base", exp_slot[PL], PL);

        // R3 R5: every lane in bank 0, with a start poke while busy (R10)
        for (int l = 0; l < LANES; l++) stim_addr[l] = l * WBYTES * BANKS;
        run_case("R3 R10", '1, 1'b0, 5);

        // R6 R8: one word for all lanes, no limiting
        for (int l = 0; l < LANES; l++) stim_addr[l] = 256 + (l % WBYTES);
        run_case("R6 R8", '1, 1'b0, 0);

        // R7: one word for all lanes, limiting on
        run_case("R7", '1, 1'b1, 0);
        check(exp_slot[0] == LANES, "R7", "model first broadcast", exp_slot[0], LANES);

        // R4: alternate lanes inactive, one hot bank
        for (int l = 0; l < LANES; l++) stim_addr[l] = l * WBYTES * BANKS;
        run_case("R4", 32'h5555_5555, 1'b0, 0);

        // R4 R9: no lane active
        run_case("R4 R9", '0, 1'b1, 0);

        // R2 R3 R6 R7: pseudo-random addresses in a small window
        for (int t = 0; t < 12; t++) begin
            logic [LANES-1:0] m;
            for (int l = 0; l < LANES; l++)
                stim_addr[l] = next_rand() % ((t % 3 == 0) ? 64 : 512);
            m = LANES'(next_rand()) | LANES'(32'h0101_0101);
            run_case((t % 2 == 0) ? "R2 R3 R6" : "R3 R7", m, 1'(t % 2), (t == 4) ? 20 : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule